// File: doc/BRIEF.md
# Quadrature Power Datapath

This block turns a stream of paired current and voltage samples from one phase into a calibrated reactive power word. Each accepted current sample enters a fixed-coefficient FIR that approximates a 90 degree shift across the fundamental and all of its harmonics. The voltage sample is delayed by the FIR group delay so that both paths stay aligned. The shifted current is multiplied by the aligned voltage. A first-order low-pass smoother then filters the product, and a configuration bit can bypass it. A signed gain correction and then a signed offset are applied to the result. At the system sample rate of 8k samples per second the result carries content up to 3.2 kHz.

A three-state controller gates the datapath. In IDLE the run input is low. The arm transition goes to ACTIVE when run rises with the calculation-off input low. The arm-muted transition goes to MUTED when run rises with calculation-off high. The stop transition returns either running state to IDLE when run falls. Calculation-off is looked at only on the arm transitions, so a change made while running does nothing. The filter history and the smoother state are cleared outside ACTIVE, and the output is forced to zero there.

Top module: `rvar_datapath`

## Requirements
- R1: Delay-line tap j (j = 0 is the newest current sample) has weight h(j − C), where C = (TAPS − 1)/2. h(m) = 0 for even m, and h(m) = round(2^14 · 2 / (π·m)) for odd m. The shifted current is the weighted sum arithmetically shifted right by 14, kept to DW+2 signed bits. The voltage used with it is the sample accepted C samples earlier.
- R2: The power product is the signed product of the shifted current and the delayed voltage.
- R3: The smoother updates once per accepted sample as y ← y + ((p − y) >>> LPF_SHIFT). When the bypass input is 1 the unfiltered product is passed on, and when it is 0 the updated y is passed on.
- R4: Gain correction gives q = f + ((f · g) >>> 23), with g a signed 24-bit word, so g = 0 gives unity.
- R5: The output word is q plus the signed offset word. A zero offset leaves q unchanged.
- R6: Output valid is high for one cycle, in the third clock cycle after the cycle in which an accepted sample is presented. The output word holds between updates.
- R7: The controller is in IDLE while run is low. When run is high, IDLE goes to ACTIVE if calculation-off is low and to MUTED if it is high. Falling run returns ACTIVE or MUTED to IDLE.
- R8: A change of calculation-off while ACTIVE or MUTED has no effect until the next stop.
- R9: Outside ACTIVE the output word is zero and output valid stays low. Input samples are ignored, and the delay lines and smoother are cleared, so each run starts from zero history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Run enable |
| calc_off_i | input | 1 | Calculation-off request, taken at arm |
| lpf_bypass_i | input | 1 | 1 passes the unfiltered product |
| in_valid_i | input | 1 | Sample strobe |
| cur_i | input | DW | Signed current sample |
| volt_i | input | DW | Signed voltage sample |
| gain_i | input | GW | Signed gain correction word |
| ofs_i | input | OUT_W | Signed offset word |
| out_valid_o | output | 1 | Output update strobe |
| var_o | output | OUT_W | Signed reactive power word |

## Verification
The bench builds the block with DW = 16 and TAPS = 7, so the bench model needs only the four odd-index weights. It also uses LPF_SHIFT = 2 so the smoother moves a visible amount within a few samples. Full-scale samples together with gains of −1 and just under +1 bring the widest product and the correction extremes within reach. The calculation-off tests then move the input while running to show it is ignored, and a restart shows the cleared history.

// File: rtl/rvar_pkg.sv
package rvar_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_MUTED  = 2'd2
    } rvar_state_t;

    localparam int COEF_FRAC = 14;
    localparam int COEF_W    = 16;

    // Quadrature FIR weight for offset m from the centre tap
    function automatic int quad_coef(input int m);
        real r;
        if (m % 2 == 0) return 0;
        r = (2.0 * real'(1 << COEF_FRAC)) / (3.14159265358979 * real'(m));
        if (r >= 0.0) return $rtoi(r + 0.5);
        return $rtoi(r - 0.5);
    endfunction

endpackage

// File: rtl/rvar_quad_shift.sv
module rvar_quad_shift
    import rvar_pkg::*;
#(
    parameter int DW   = 16,
    parameter int TAPS = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear_i,
    input  logic                 take_i,
    input  logic signed [DW-1:0] cur_i,
    input  logic signed [DW-1:0] volt_i,
    output logic signed [DW+1:0] quad_o,
    output logic signed [DW-1:0] volt_o,
    output logic                 vld_o
);
    localparam int CTR = (TAPS - 1) / 2;
    localparam int IW  = DW + 2;
    localparam int SW  = DW + COEF_W + $clog2(TAPS) + 1;

    logic signed [DW-1:0] cur_line  [TAPS];
    logic signed [DW-1:0] volt_line [CTR+1];
    logic signed [SW-1:0] tap_prod  [TAPS];
    logic signed [SW-1:0] sum;

    for (genvar j = 0; j < TAPS; j++) begin : g_cur
        localparam int TAP_W = quad_coef(j - CTR);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       cur_line[j] <= '0;
            else if (clear_i) cur_line[j] <= '0;
            else if (take_i) begin
                if (j == 0) cur_line[j] <= cur_i;
                else        cur_line[j] <= cur_line[(j == 0) ? 0 : j-1];
            end
        end
        assign tap_prod[j] = SW'(cur_line[j]) * SW'(TAP_W);
    end

    for (genvar k = 0; k <= CTR; k++) begin : g_volt
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       volt_line[k] <= '0;
            else if (clear_i) volt_line[k] <= '0;
            else if (take_i) begin
                if (k == 0) volt_line[k] <= volt_i;
                else        volt_line[k] <= volt_line[(k == 0) ? 0 : k-1];
            end
        end
    end

    always_comb begin
        sum = '0;
        for (int j = 0; j < TAPS; j++) sum = sum + tap_prod[j];
    end

    assign quad_o = IW'(sum >>> COEF_FRAC);
    assign volt_o = volt_line[CTR];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_o <= 1'b0;
        else        vld_o <= take_i && !clear_i;
    end

    // R1: newest tap holds the sample just accepted
    assert_newest_tap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !clear_i) |=> (cur_line[0] == $past(cur_i)));

endmodule

// File: rtl/rvar_smooth.sv
module rvar_smooth #(
    parameter int IW        = 18,
    parameter int DW        = 16,
    parameter int LPF_SHIFT = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear_i,
    input  logic                    vld_i,
    input  logic signed [IW-1:0]    quad_i,
    input  logic signed [DW-1:0]    volt_i,
    input  logic                    bypass_i,
    output logic signed [IW+DW-1:0] filt_o,
    output logic                    vld_o
);
    localparam int PW = IW + DW;

    logic signed [PW-1:0] prod, prod_q, y_q, y_d;
    logic signed [PW:0]   diff, step;

    assign prod = PW'(quad_i) * PW'(volt_i);
    assign diff = (PW+1)'(prod) - (PW+1)'(y_q);
    assign step = diff >>> LPF_SHIFT;
    assign y_d  = y_q + PW'(step);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prod_q <= '0;
            y_q    <= '0;
            vld_o  <= 1'b0;
        end else if (clear_i) begin
            prod_q <= '0;
            y_q    <= '0;
            vld_o  <= 1'b0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) begin
                prod_q <= prod;
                y_q    <= y_d;
            end
        end
    end

    assign filt_o = bypass_i ? prod_q : y_q;

    // R3: each update moves the state toward the product, never past it
    assert_lpf_between_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && !clear_i) |=>
            (($past(prod) >= $past(y_q)) ?
                (y_q >= $past(y_q) && y_q <= $past(prod)) :
                (y_q <= $past(y_q) && y_q >= $past(prod))));

endmodule

// File: rtl/rvar_calib.sv
module rvar_calib #(
    parameter int PW    = 34,
    parameter int GW    = 24,
    parameter int OUT_W = 40
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    active_i,
    input  logic                    vld_i,
    input  logic signed [PW-1:0]    filt_i,
    input  logic signed [GW-1:0]    gain_i,
    input  logic signed [OUT_W-1:0] ofs_i,
    output logic signed [OUT_W-1:0] out_o,
    output logic                    vld_o
);
    localparam int MW = PW + GW;
    localparam int QW = PW + 2;

    logic signed [MW-1:0]    mul, corr;
    logic signed [QW-1:0]    q;
    logic signed [OUT_W-1:0] res;

    assign mul  = MW'(filt_i) * MW'(gain_i);
    assign corr = mul >>> (GW - 1);
    assign q    = QW'(filt_i) + QW'(corr);
    assign res  = OUT_W'(q) + ofs_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_o <= '0;
            vld_o <= 1'b0;
        end else if (!active_i) begin
            out_o <= '0;
            vld_o <= 1'b0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) out_o <= res;
        end
    end

    // R9: nothing leaves the block outside the active state
    assert_muted_output_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> (!vld_o && out_o == '0));

    // R4 / R5: zero gain and zero offset pass the filtered value unchanged
    assert_unity_gain_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && vld_i && gain_i == '0 && ofs_i == '0) |=>
            (out_o == OUT_W'($past(filt_i))));

    // R6: output holds between updates
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && !vld_i) |=> $stable(out_o));

endmodule

// File: rtl/rvar_datapath.sv
module rvar_datapath
    import rvar_pkg::*;
#(
    parameter int DW        = 16,
    parameter int TAPS      = 15,
    parameter int LPF_SHIFT = 10,
    parameter int GW        = 24,
    parameter int OUT_W     = 40
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run_i,
    input  logic                    calc_off_i,
    input  logic                    lpf_bypass_i,
    input  logic                    in_valid_i,
    input  logic signed [DW-1:0]    cur_i,
    input  logic signed [DW-1:0]    volt_i,
    input  logic signed [GW-1:0]    gain_i,
    input  logic signed [OUT_W-1:0] ofs_i,
    output logic                    out_valid_o,
    output logic signed [OUT_W-1:0] var_o
);
    localparam int IW = DW + 2;
    localparam int PW = IW + DW;

    rvar_state_t state_q, state_d;
    logic        active, clear, take;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (run_i) state_d = calc_off_i ? ST_MUTED : ST_ACTIVE;
            ST_ACTIVE: if (!run_i) state_d = ST_IDLE;
            ST_MUTED:  if (!run_i) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs of the controller
    always_comb begin
        active = (state_q == ST_ACTIVE);
        clear  = !active;
        take   = active && in_valid_i;
    end

    logic signed [IW-1:0] quad;
    logic signed [DW-1:0] volt_d;
    logic                 s0_vld, s1_vld;
    logic signed [PW-1:0] filt;

    rvar_quad_shift #(.DW(DW), .TAPS(TAPS)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear),
        .take_i  (take),
        .cur_i   (cur_i),
        .volt_i  (volt_i),
        .quad_o  (quad),
        .volt_o  (volt_d),
        .vld_o   (s0_vld)
    );

    rvar_smooth #(.IW(IW), .DW(DW), .LPF_SHIFT(LPF_SHIFT)) u_smooth (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (clear),
        .vld_i    (s0_vld),
        .quad_i   (quad),
        .volt_i   (volt_d),
        .bypass_i (lpf_bypass_i),
        .filt_o   (filt),
        .vld_o    (s1_vld)
    );

    rvar_calib #(.PW(PW), .GW(GW), .OUT_W(OUT_W)) u_calib (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (active),
        .vld_i    (s1_vld),
        .filt_i   (filt),
        .gain_i   (gain_i),
        .ofs_i    (ofs_i),
        .out_o    (var_o),
        .vld_o    (out_valid_o)
    );

    // R8: calculation-off is ignored once running
    assert_muted_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MUTED && run_i) |=> (state_q == ST_MUTED));
    assert_active_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && run_i) |=> (state_q == ST_ACTIVE));

    // R7: dropping run always returns to idle
    assert_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (state_q == ST_IDLE));

    // R6: every output strobe traces back to an accepted sample three cycles earlier
    assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> $past(in_valid_i && state_q == ST_ACTIVE, 3));

endmodule

// File: tb/rvar_datapath_tb.sv
`timescale 1ns/1ps
module rvar_datapath_tb;
    localparam int DW = 16, TAPS = 7, SH = 2, GW = 24, OUT_W = 40;
    localparam int CTR = (TAPS - 1) / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0, calc_off = 1'b0, byp = 1'b1, in_valid = 1'b0;
    logic signed [DW-1:0]    cur = '0, volt = '0;
    logic signed [GW-1:0]    gain = '0;
    logic signed [OUT_W-1:0] ofs = '0;
    logic                    out_valid;
    logic signed [OUT_W-1:0] var_w;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rvar_datapath #(.DW(DW), .TAPS(TAPS), .LPF_SHIFT(SH), .GW(GW), .OUT_W(OUT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .run_i(run), .calc_off_i(calc_off),
        .lpf_bypass_i(byp), .in_valid_i(in_valid), .cur_i(cur), .volt_i(volt),
        .gain_i(gain), .ofs_i(ofs), .out_valid_o(out_valid), .var_o(var_w)
    );

    // cur, volt, bypass, gain, offset
    localparam int VEC [14][5] = '{
        '{  12000,   8000, 1,        0,      0},
        '{  -9000,  15000, 1,        0,      0},
        '{  32767, -32768, 1,        0,      0},
        '{ -32768, -32768, 1,        0,      0},
        '{  20000,  30000, 1,        0,      0},
        '{   5000,  20000, 1,  4194304,      0},
        '{   7000,  -3000, 1, -4194304,      0},
        '{   1000,  30000, 1,        0, 123456},
        '{  22000,  11000, 1,  8388607,  -5000},
        '{ -32768,  32767, 1, -8388608,      0},
        '{   4000,   4000, 0,        0,      0},
        '{  -4000,  25000, 0,        0,      0},
        '{  16000, -12000, 0,        0,      0},
        '{   3000,   9000, 0,  1000000,     77}
    };

    // Independent reference of the requirements
    longint hc [TAPS];
    longint hv [TAPS];
    longint ys;

    function automatic longint weight(input int m);
        real r;
        if (m % 2 == 0) return 0;
        r = 32768.0 / (3.14159265358979 * real'(m));
        if (r >= 0.0) return longint'($rtoi(r + 0.5));
        return longint'($rtoi(r - 0.5));
    endfunction

    task automatic model_clear();
        for (int j = 0; j < TAPS; j++) begin hc[j] = 0; hv[j] = 0; end
        ys = 0;
    endtask

    task automatic model_step(input longint c, input longint v, input bit b,
                              input longint g, input longint o, output longint res);
        longint s, p, f, q;
        for (int j = TAPS - 1; j > 0; j--) begin hc[j] = hc[j-1]; hv[j] = hv[j-1]; end
        hc[0] = c; hv[0] = v;
        s = 0;
        for (int j = 0; j < TAPS; j++) s = s + weight(j - CTR) * hc[j];
        s = s >>> 14;
        s = (s <<< (64 - (DW + 2))) >>> (64 - (DW + 2));
        p = s * hv[CTR];
        ys = ys + ((p - ys) >>> SH);
        f = b ? p : ys;
        q = f + ((f * g) >>> 23);
        res = q + o;
    endtask

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Present one sample; accepted==1 expects an output update (R6)
    task automatic send(input int c, input int v, input bit b, input int g,
                        input int o, input bit accepted, input string tag);
        longint exp;
        @(negedge clk);
        cur = DW'(c); volt = DW'(v); byp = b; gain = GW'(g); ofs = OUT_W'(o);
        in_valid = 1'b1;
        exp = 0;
        if (accepted) model_step(c, v, b, g, o, exp);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b0, "R6 early valid", longint'(out_valid), 0);
        @(negedge clk);
        chk(out_valid == 1'b0, "R6 early valid", longint'(out_valid), 0);
        @(negedge clk);
        chk(out_valid == accepted, {tag, " valid"}, longint'(out_valid), longint'(accepted));
        chk(var_w == OUT_W'(exp), tag, longint'(var_w), exp);
        @(negedge clk);
        chk(out_valid == 1'b0, "R6 single pulse", longint'(out_valid), 0);
        chk(var_w == OUT_W'(exp), "R6 hold", longint'(var_w), exp);
    endtask

    function automatic string row_tag(input int i);
        if (VEC[i][2] == 0) return "R3 smoother";
        if (VEC[i][3] != 0) return "R4 gain";
        if (VEC[i][4] != 0) return "R5 offset";
        return "R1 R2 quadrature product";
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0 && var_w == '0, "R9 reset state", longint'(var_w), 0);

        // R7: arm into ACTIVE
        run = 1'b1; calc_off = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 14; i++)
            send(VEC[i][0], VEC[i][1], VEC[i][2] != 0, VEC[i][3], VEC[i][4], 1'b1, row_tag(i));

        // R8: calculation-off raised while active is ignored
        calc_off = 1'b1;
        send(11000, -7000, 1'b1, 0, 0, 1'b1, "R8 off ignored while active");
        send(-6000, 14000, 1'b0, 0, 9, 1'b1, "R8 off ignored while active");

        // R9: stop, then samples while idle change nothing
        @(negedge clk); run = 1'b0;
        repeat (2) @(negedge clk);
        chk(out_valid == 1'b0 && var_w == '0, "R9 idle output zero", longint'(var_w), 0);
        send(30000, 30000, 1'b1, 0, 0, 1'b0, "R9 idle sample ignored");

        // R7: arm with calculation-off set gives MUTED
        calc_off = 1'b1; run = 1'b1;
        @(negedge clk);
        send(25000, -25000, 1'b1, 0, 500, 1'b0, "R7 muted run");
        // R8: clearing calculation-off while muted is ignored
        calc_off = 1'b0;
        send(25000, -25000, 1'b1, 0, 500, 1'b0, "R8 clear ignored while muted");
        send(-1000, 12345, 1'b1, 0, 0, 1'b0, "R8 clear ignored while muted");

        // R9: restart starts from cleared history
        @(negedge clk); run = 1'b0;
        repeat (2) @(negedge clk);
        run = 1'b1;
        @(negedge clk);
        model_clear();
        for (int k = 0; k < 5; k++)
            send(9000 + 1000 * k, 13000 - 3000 * k, 1'b0, 0, 0, 1'b1, "R9 restart from zero");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule